// File: doc/BRIEF.md
# Colour Lookup Table Register Port

This block is the host-side register port of a colour lookup table. It holds a 256-entry main colour map and an 8-entry overlay map, each entry a 24-bit RGB value, and an 8-bit address register that points at the entry being transferred. The host reaches four byte-wide registers through a 2-bit register select with separate write and read strobes. Colour data moves one byte at a time in red, green, blue order, and the address steps forward by itself after each complete triplet. Host software can stream a whole palette by loading the address once and writing bytes back to back.

A separate lookup port, driven by the pixel path, presents a pixel index and an overlay flag. One clock later it returns the 24-bit colour of the selected entry. Gamma correction, the analog converter and video timing belong to other blocks.

Register select codes: 0 = address, 1 = main map data, 2 = control, 3 = overlay map data. In every entry red is bits 7:0, green is bits 15:8 and blue is bits 23:16.

Top module: `palette_regport`

## Requirements
- R1: After a synchronous active-low reset, the address and the byte pointer are zero, every main and overlay entry is zero, and `rd_data` is zero.
- R2: A write to register 0 loads the address from `wr_data` and returns the byte pointer to the red position, including in the middle of a triplet. A read of register 0 places the current address on `rd_data` one clock after the strobe.
- R3: Three writes to register 1 supply red, then green, then blue. The third write stores {blue, green, red} into main entry `address`.
- R4: After a main-map commit the byte pointer returns to red and the address increments modulo 256, so 255 wraps to 0.
- R5: Three writes to register 3 fill overlay entry `address[2:0]` in the same order. After the third write the address becomes (address + 1) modulo 8.
- R6: A read of register 1 or 3 at the red position copies the whole addressed entry into a holding buffer and returns red. The next two reads return green and blue from that buffer. After the blue byte the address advances as in R4 (main map) or R5 (overlay map). Every read byte appears on `rd_data` one clock after its strobe.
- R7: A write or read of register 2 sets the address to (address + 1) modulo 8 and leaves the byte pointer unchanged. A read of register 2 returns zero.
- R8: A main entry that has received only one or two of its three bytes keeps its previous value on the lookup port.
- R9: When `pix_ovl` is 1, the lookup port returns overlay entry `pix_idx[2:0]`. When `pix_ovl` is 0, it returns main entry `pix_idx`. The result appears on `pix_rgb` one clock after the inputs are sampled.
- R10: A lookup sampled on the same edge as a commit to the same entry returns the value from before the commit. A lookup on the following edge returns the new value.
- R11: When `wr_en` and `rd_en` are both high, only the write is performed, and `rd_data` keeps its previous value. With neither strobe high, the address, pointer and `rd_data` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_sel | input | 2 | Register select (0 address, 1 main, 2 control, 3 overlay) |
| wr_en | input | 1 | Write strobe for one byte |
| rd_en | input | 1 | Read strobe for one byte |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Read byte, valid one clock after `rd_en` |
| pix_idx | input | 8 | Lookup index |
| pix_ovl | input | 1 | Lookup selects the overlay map |
| pix_rgb | output | 24 | Lookup colour, one clock of latency |

## Verification
A host commit and a pixel lookup can hit the same entry on the same edge. The bench provokes this on purpose: it drives the blue byte and a lookup of the target index together. In the directed cases and in the random traffic it expects the old colour on that edge and the new colour on the next lookup. The random stimulus also pairs partial triplets with lookups, and write-with-read strobes with map traffic. An independent bench model decides every expected `rd_data` and `pix_rgb` byte.

// File: rtl/palette_pkg.sv
// Shared definitions for the colour lookup table register port.
// Assumes a 2-bit register select and a three-byte colour triplet.
package palette_pkg;
    typedef enum logic [1:0] {
        SEL_ADDR = 2'd0,
        SEL_MAIN = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_OVL  = 2'd3
    } regsel_e;

    typedef logic [1:0] tri_ptr_t;

    localparam tri_ptr_t PTR_RED  = 2'd0;
    localparam tri_ptr_t PTR_GRN  = 2'd1;
    localparam tri_ptr_t PTR_BLU  = 2'd2;
    localparam int       TRIPLET  = 3;
endpackage

// File: rtl/palette_seq.sv
// Address and byte-pointer sequencer.
// Decodes host strobes into commit and step events, keeps the address
// register, the triplet pointer and the red/green staging bytes.
// Assumes CH_W >= ADDR_W and OVL_W < ADDR_W. A write strobe takes
// priority over a read strobe in the same cycle.
module palette_seq
    import palette_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int OVL_W  = 3,
    parameter int CH_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        reg_sel,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [CH_W-1:0]   wr_data,
    output logic [ADDR_W-1:0] addr_q,
    output tri_ptr_t          ptr_q,
    output logic [CH_W-1:0]   stg_red,
    output logic [CH_W-1:0]   stg_grn,
    output logic              commit_main,
    output logic              commit_ovl
);
    regsel_e           sel;
    logic              wr_act;
    logic              rd_act;
    logic              is_map;
    logic              byte_step;
    logic              at_last;
    logic              wrap_main;
    logic              wrap_ovl;
    logic              ctrl_hit;
    logic [OVL_W-1:0]  ovl_next;

    // Decode the strobes and the register select into step events.
    always_comb begin
        sel         = regsel_e'(reg_sel);
        wr_act      = wr_en;
        rd_act      = rd_en & ~wr_en;
        is_map      = (sel == SEL_MAIN) || (sel == SEL_OVL);
        byte_step   = is_map && (wr_act || rd_act);
        at_last     = (ptr_q == PTR_BLU);
        wrap_main   = byte_step && at_last && (sel == SEL_MAIN);
        wrap_ovl    = byte_step && at_last && (sel == SEL_OVL);
        ctrl_hit    = (sel == SEL_CTRL) && (wr_act || rd_act);
        commit_main = wr_act && at_last && (sel == SEL_MAIN);
        commit_ovl  = wr_act && at_last && (sel == SEL_OVL);
        ovl_next    = addr_q[OVL_W-1:0] + 1'b1;
    end

    // Address register: host load, triplet advance or control step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (wr_act && (sel == SEL_ADDR)) begin
            addr_q <= wr_data[ADDR_W-1:0];
        end else if (wrap_main) begin
            addr_q <= addr_q + 1'b1;
        end else if (wrap_ovl || ctrl_hit) begin
            addr_q <= ADDR_W'(ovl_next);
        end
    end

    // Triplet byte pointer: cleared by address load, steps per map byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= PTR_RED;
        end else if (wr_act && (sel == SEL_ADDR)) begin
            ptr_q <= PTR_RED;
        end else if (byte_step) begin
            ptr_q <= at_last ? PTR_RED : ptr_q + 1'b1;
        end
    end

    // Staging bytes hold red and green until the blue byte commits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_red <= '0;
            stg_grn <= '0;
        end else if (wr_act && is_map) begin
            if (ptr_q == PTR_RED) stg_red <= wr_data;
            if (ptr_q == PTR_GRN) stg_grn <= wr_data;
        end
    end
endmodule

// File: rtl/palette_store.sv
// Main and overlay colour storage with the pixel lookup port.
// Each entry is its own register, written only on a commit.
// The lookup result is registered and reads the pre-commit contents
// when a commit and a lookup fall on the same edge.
module palette_store #(
    parameter int ADDR_W = 8,
    parameter int OVL_W  = 3,
    parameter int CH_W   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                commit_main,
    input  logic                commit_ovl,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [3*CH_W-1:0]   commit_data,
    input  logic [ADDR_W-1:0]   pix_idx,
    input  logic                pix_ovl,
    output logic [3*CH_W-1:0]   pix_rgb,
    output logic [3*CH_W-1:0]   main_at_addr,
    output logic [3*CH_W-1:0]   ovl_at_addr
);
    localparam int MAIN_N = 1 << ADDR_W;
    localparam int OVL_N  = 1 << OVL_W;
    localparam int ENT_W  = 3 * CH_W;

    logic [ENT_W-1:0] main_arr [MAIN_N];
    logic [ENT_W-1:0] ovl_arr  [OVL_N];

    // One register per main entry, loaded when its address commits.
    for (genvar i = 0; i < MAIN_N; i++) begin : g_main
        logic [ENT_W-1:0] ent_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_q <= '0;
            end else if (commit_main && (addr == ADDR_W'(i))) begin
                ent_q <= commit_data;
            end
        end
        assign main_arr[i] = ent_q;
    end

    // One register per overlay entry, addressed by the low address bits.
    for (genvar j = 0; j < OVL_N; j++) begin : g_ovl
        logic [ENT_W-1:0] ent_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_q <= '0;
            end else if (commit_ovl && (addr[OVL_W-1:0] == OVL_W'(j))) begin
                ent_q <= commit_data;
            end
        end
        assign ovl_arr[j] = ent_q;
    end

    // Entries under the host address, for the read holding buffer.
    always_comb begin
        main_at_addr = main_arr[addr];
        ovl_at_addr  = ovl_arr[addr[OVL_W-1:0]];
    end

    // Registered pixel lookup with one cycle of latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_rgb <= '0;
        end else if (pix_ovl) begin
            pix_rgb <= ovl_arr[pix_idx[OVL_W-1:0]];
        end else begin
            pix_rgb <= main_arr[pix_idx];
        end
    end
endmodule

// File: rtl/palette_rdport.sv
// Host read path: holding buffer and registered read byte.
// The red read of a triplet captures the whole entry. The green and blue
// reads come from that capture, so a later commit cannot tear a triplet.
module palette_rdport
    import palette_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CH_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        reg_sel,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  tri_ptr_t          ptr,
    input  logic [3*CH_W-1:0] main_ent,
    input  logic [3*CH_W-1:0] ovl_ent,
    output logic [CH_W-1:0]   rd_data
);
    localparam int ENT_W = 3 * CH_W;

    regsel_e          sel;
    logic             rd_act;
    logic [ENT_W-1:0] src_ent;
    logic [ENT_W-1:0] hold_q;

    // Pick the map that the current read targets.
    always_comb begin
        sel     = regsel_e'(reg_sel);
        rd_act  = rd_en & ~wr_en;
        src_ent = (sel == SEL_OVL) ? ovl_ent : main_ent;
    end

    // Capture the whole entry on the red read of a triplet.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (rd_act && (sel == SEL_MAIN || sel == SEL_OVL) && ptr == PTR_RED) begin
            hold_q <= src_ent;
        end
    end

    // Registered read byte, updated only by an accepted read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_act) begin
            unique case (sel)
                SEL_ADDR: rd_data <= CH_W'(addr);
                SEL_CTRL: rd_data <= '0;
                default: begin
                    if (ptr == PTR_RED) rd_data <= src_ent[CH_W-1:0];
                    else                rd_data <= hold_q[ptr*CH_W +: CH_W];
                end
            endcase
        end
    end
endmodule

// File: rtl/palette_regport.sv
// Colour lookup table register port, top level.
// Joins the sequencer, the colour storage and the host read path.
// Assumes one byte per host access and a 2-bit register select.
module palette_regport
    import palette_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int OVL_W  = 3,
    parameter int CH_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        reg_sel,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [CH_W-1:0]   wr_data,
    output logic [CH_W-1:0]   rd_data,
    input  logic [ADDR_W-1:0] pix_idx,
    input  logic              pix_ovl,
    output logic [3*CH_W-1:0] pix_rgb
);
    localparam int ENT_W = 3 * CH_W;

    logic [ADDR_W-1:0] addr_q;
    tri_ptr_t          ptr_q;
    logic [CH_W-1:0]   stg_red;
    logic [CH_W-1:0]   stg_grn;
    logic              commit_main;
    logic              commit_ovl;
    logic [ENT_W-1:0]  commit_data;
    logic [ENT_W-1:0]  main_at_addr;
    logic [ENT_W-1:0]  ovl_at_addr;

    // Blue is the byte arriving now; red and green come from staging.
    assign commit_data = {wr_data, stg_grn, stg_red};

    palette_seq #(.ADDR_W(ADDR_W), .OVL_W(OVL_W), .CH_W(CH_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en),
        .rd_en(rd_en), .wr_data(wr_data), .addr_q(addr_q), .ptr_q(ptr_q),
        .stg_red(stg_red), .stg_grn(stg_grn),
        .commit_main(commit_main), .commit_ovl(commit_ovl)
    );

    palette_store #(.ADDR_W(ADDR_W), .OVL_W(OVL_W), .CH_W(CH_W)) u_store (
        .clk(clk), .rst_n(rst_n), .commit_main(commit_main),
        .commit_ovl(commit_ovl), .addr(addr_q), .commit_data(commit_data),
        .pix_idx(pix_idx), .pix_ovl(pix_ovl), .pix_rgb(pix_rgb),
        .main_at_addr(main_at_addr), .ovl_at_addr(ovl_at_addr)
    );

    palette_rdport #(.ADDR_W(ADDR_W), .CH_W(CH_W)) u_rd (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en),
        .rd_en(rd_en), .addr(addr_q), .ptr(ptr_q), .main_ent(main_at_addr),
        .ovl_ent(ovl_at_addr), .rd_data(rd_data)
    );
endmodule

// File: rtl/palette_regport_chk.sv
// Property checker for the register port, attached by bind.
// Watches the host strobes against the address and the byte pointer.
module palette_regport_chk #(
    parameter int ADDR_W = 8,
    parameter int OVL_W  = 3,
    parameter int CH_W   = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        reg_sel,
    input logic              wr_en,
    input logic              rd_en,
    input logic [CH_W-1:0]   wr_data,
    input logic [ADDR_W-1:0] addr,
    input logic [1:0]        ptr
);
    logic [OVL_W-1:0] ovl_nxt;
    logic             map_acc;
    assign ovl_nxt = addr[OVL_W-1:0] + 1'b1;
    assign map_acc = reg_sel[0] && (wr_en || rd_en);

    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (addr == '0 && ptr == 2'd0));

    assert_addr_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_sel == 2'd0) |=> (addr == $past(wr_data[ADDR_W-1:0]) && ptr == 2'd0));

    assert_main_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (map_acc && reg_sel == 2'd1 && ptr == 2'd2) |=> (addr == $past(addr) + 1'b1 && ptr == 2'd0));

    assert_ovl_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (map_acc && reg_sel == 2'd3 && ptr == 2'd2) |=> (addr == ADDR_W'($past(ovl_nxt)) && ptr == 2'd0));

    assert_byte_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (map_acc && ptr != 2'd2) |=> (ptr == $past(ptr) + 1'b1 && $stable(addr)));

    assert_ctrl_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel == 2'd2 && (wr_en || rd_en)) |=> (addr == ADDR_W'($past(ovl_nxt)) && $stable(ptr)));

    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en || rd_en) |=> ($stable(addr) && $stable(ptr)));
endmodule

bind palette_regport palette_regport_chk #(.ADDR_W(ADDR_W), .OVL_W(OVL_W), .CH_W(CH_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en), .rd_en(rd_en),
    .wr_data(wr_data), .addr(addr_q), .ptr(ptr_q)
);

// File: tb/palette_regport_test.sv
// Self-checking bench: directed corner cases plus seeded random traffic,
// compared against a behavioural model of the register port.
module palette_regport_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  reg_sel = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  rd_data;
    logic [7:0]  pix_idx = '0;
    logic        pix_ovl = 1'b0;
    logic [23:0] pix_rgb;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [23:0] m_main [256];
    logic [23:0] m_ovl  [8];
    logic [7:0]  m_addr;
    int          m_ptr;
    logic [7:0]  m_red, m_grn, m_rd;
    logic [23:0] m_hold;

    always #5 clk = ~clk;

    palette_regport uut (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en),
        .rd_en(rd_en), .wr_data(wr_data), .rd_data(rd_data),
        .pix_idx(pix_idx), .pix_ovl(pix_ovl), .pix_rgb(pix_rgb)
    );

    function automatic logic [23:0] entry_of(bit ovl, logic [7:0] idx);
        return ovl ? m_ovl[idx[2:0]] : m_main[idx];
    endfunction

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    // Apply one access and one lookup for a clock, update the model, check.
    task automatic op(input int sel, input bit wr, input bit rd, input logic [7:0] d,
                      input logic [7:0] pidx, input bit povl, input string req);
        logic [23:0] exp_pix;
        reg_sel = 2'(sel); wr_en = wr; rd_en = rd; wr_data = d;
        pix_idx = pidx; pix_ovl = povl;
        exp_pix = entry_of(povl, pidx);
        @(posedge clk);
        if (sel == 0) begin
            if (wr) begin m_addr = d; m_ptr = 0; end
            else if (rd) m_rd = m_addr;
        end else if (sel == 2) begin
            if (wr || rd) m_addr = {5'd0, m_addr[2:0] + 3'd1};
            if (rd && !wr) m_rd = 8'h00;
        end else if (wr || rd) begin
            if (wr) begin
                if (m_ptr == 0) m_red = d;
                else if (m_ptr == 1) m_grn = d;
                else if (sel == 1) m_main[m_addr] = {d, m_grn, m_red};
                else m_ovl[m_addr[2:0]] = {d, m_grn, m_red};
            end else begin
                if (m_ptr == 0) m_hold = entry_of(sel == 3, m_addr);
                m_rd = m_hold[m_ptr*8 +: 8];
            end
            if (m_ptr == 2) begin
                m_ptr = 0;
                m_addr = (sel == 1) ? m_addr + 8'd1 : {5'd0, m_addr[2:0] + 3'd1};
            end else m_ptr++;
        end
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        check({req, " rd_data"}, 32'(rd_data), 32'(m_rd));
        check({req, " pix_rgb"}, 32'(pix_rgb), 32'(exp_pix));
    endtask

    task automatic rd_addr(input logic [7:0] exp, input string req);
        op(0, 0, 1, 8'h00, 8'h00, 0, req);
        check({req, " address"}, 32'(rd_data), 32'(exp));
    endtask

    task automatic lookup(input logic [7:0] idx, input bit ovl,
                          input logic [23:0] exp, input string req);
        op(0, 0, 0, 8'h00, idx, ovl, req);
        @(posedge clk);
        @(negedge clk);
        check({req, " lookup"}, 32'(pix_rgb), 32'(exp));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 256; i++) m_main[i] = '0;
        for (int i = 0; i < 8; i++) m_ovl[i] = '0;
        m_addr = '0; m_ptr = 0; m_red = '0; m_grn = '0; m_rd = '0; m_hold = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state on both outputs and an untouched entry.
        check("R1 rd_data", 32'(rd_data), 32'h0);
        check("R1 pix_rgb", 32'(pix_rgb), 32'h0);
        lookup(8'hA7, 0, 24'h0, "R1");
        rd_addr(8'h00, "R1");
        // R2: load and read back the address.
        op(0, 1, 0, 8'h10, 0, 0, "R2");
        rd_addr(8'h10, "R2");
        // R3/R4: triplet commit, byte order, address increment.
        op(1, 1, 0, 8'h11, 0, 0, "R3");
        op(1, 1, 0, 8'h22, 0, 0, "R3");
        op(1, 1, 0, 8'h33, 0, 0, "R3");
        lookup(8'h10, 0, 24'h332211, "R3");
        rd_addr(8'h11, "R4");
        op(0, 1, 0, 8'hFF, 0, 0, "R4");
        op(1, 1, 0, 8'hA1, 0, 0, "R4");
        op(1, 1, 0, 8'hB2, 0, 0, "R4");
        op(1, 1, 0, 8'hC3, 0, 0, "R4");
        rd_addr(8'h00, "R4 wrap");
        // R8/R10: partial entry hidden, same-edge lookup sees old value.
        op(0, 1, 0, 8'h05, 0, 0, "R8");
        op(1, 1, 0, 8'h5A, 8'h05, 0, "R8");
        op(1, 1, 0, 8'h6B, 8'h05, 0, "R8");
        lookup(8'h05, 0, 24'h0, "R8");
        op(1, 1, 0, 8'h7C, 8'h05, 0, "R10");
        check("R10 old value", 32'(pix_rgb), 32'h0);
        lookup(8'h05, 0, 24'h7C6B5A, "R10 new value");
        // R5/R9: overlay triplet and wrap at 8.
        op(0, 1, 0, 8'hC6, 0, 0, "R5");
        op(3, 1, 0, 8'h01, 0, 0, "R5");
        op(3, 1, 0, 8'h02, 0, 0, "R5");
        op(3, 1, 0, 8'h03, 0, 0, "R5");
        rd_addr(8'h07, "R5");
        op(3, 1, 0, 8'h0A, 0, 0, "R5");
        op(3, 1, 0, 8'h0B, 0, 0, "R5");
        op(3, 1, 0, 8'h0C, 0, 0, "R5");
        rd_addr(8'h00, "R5 wrap");
        lookup(8'hFE, 1, 24'h030201, "R9 overlay");
        lookup(8'hC6, 0, 24'h0, "R9 main");
        // R7: control access steps the address modulo 8.
        op(0, 1, 0, 8'h0F, 0, 0, "R7");
        op(2, 1, 0, 8'h99, 0, 0, "R7");
        rd_addr(8'h00, "R7");
        op(2, 0, 1, 8'h00, 0, 0, "R7");
        check("R7 read zero", 32'(rd_data), 32'h0);
        rd_addr(8'h01, "R7");
        // R6: triplet read of main entry 0x10, then address advance.
        op(0, 1, 0, 8'h10, 0, 0, "R6");
        op(1, 0, 1, 0, 0, 0, "R6"); check("R6 red", 32'(rd_data), 32'h11);
        op(1, 0, 1, 0, 0, 0, "R6"); check("R6 green", 32'(rd_data), 32'h22);
        op(1, 0, 1, 0, 0, 0, "R6"); check("R6 blue", 32'(rd_data), 32'h33);
        rd_addr(8'h11, "R6");
        // R2: address load in mid-triplet restarts at red.
        op(0, 1, 0, 8'h10, 0, 0, "R2");
        op(1, 0, 1, 0, 0, 0, "R2");
        op(0, 1, 0, 8'h10, 0, 0, "R2");
        op(1, 0, 1, 0, 0, 0, "R2"); check("R2 restart red", 32'(rd_data), 32'h11);
        // R11: write and read together perform only the write.
        op(0, 1, 1, 8'h42, 0, 0, "R11");
        check("R11 rd_data held", 32'(rd_data), 32'h11);
        rd_addr(8'h42, "R11");
        // Random traffic against the model.
        for (int n = 0; n < 3000; n++) begin
            int s;
            bit w, r;
            s = int'($urandom_range(0, 3));
            w = ($urandom_range(0, 3) != 0);
            r = ($urandom_range(0, 3) == 0);
            if (s == 0 && w && $urandom_range(0, 3) != 0) w = 1'b0;
            op(s, w, r, 8'($urandom), 8'($urandom), 1'($urandom), "R9 random");
        end
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule